// File: doc/BRIEF.md
# Paged segment relocation unit

This block sits between a 16-bit processor's address path and an 18-bit physical memory bus. It translates each virtual byte address into a physical address. The virtual space is cut into eight equal pages, and the top address bits select the page. Each page has a relocation base and a descriptor. There are two sets of these registers: one set serves references made through the program counter (instruction space), and the other serves all remaining references (data space). The descriptor says which end of the page holds the valid part and how large it is, in 64-byte blocks. It also gives the access mode. An access that falls outside the valid part, hits a page with no access, or writes a read-only page is aborted, and an error flag is raised in the control/status register.

While the enable bit of the control/status register is clear, translation is bypassed. Pages 0 to 6 then map to the same physical addresses, and page 7 maps onto the top 8 KB of physical space. A second register captures the virtual address of every instruction fetch. After a fault, the control/status register keeps the page and space of the first fault until software clears the flags. All registers are loaded through a one-cycle write port. Translation and abort are combinational within the request cycle, and status updates land on the following clock edge.

Top module: `seg_reloc_unit`

## Requirements
- R1: With translation enabled, pa equals (relocation value × 64 + va[12:0]) modulo 2^18, where the page is va[15:13].
- R2: A request with req_ispace=1 uses the instruction-space register set, and req_ispace=0 uses the data-space set. The two sets hold separate values.
- R3: With descriptor bit 3 clear (lower part valid), a block index va[12:6] greater than the length field aborts the request and sets control/status bit 14.
- R4: With descriptor bit 3 set (upper part valid), a block index less than or equal to the length field aborts the request and sets control/status bit 14.
- R5: The access field is descriptor bits [1:0]. Codes 00 and 10 mean no access: any request aborts and sets control/status bit 15. Code 01 is read-only: reads pass, and writes abort and set bit 13. Code 11 allows reads and writes.
- R6: Translation is on only while control/status bit 0 is 1. While it is 0, no request aborts, pa = va for pages 0–6, and page 7 maps to pa = 18'o760000 + va[12:0].
- R7: On the edge after a request with req_fetch=1, the fetch capture register holds that request's va. Other requests leave it unchanged.
- R8: On the first abort while no error flag is set, control/status bits [3:1] take the page number and bit 4 takes the space (1 = instruction). While any flag is set, later aborts only add flags, and page and space stay frozen. A software write replaces the whole control/status register.
- R9: The write address is {kind[1:0], space, page[2:0]}. Kind 0 loads relocation bits [11:0]. Kind 1 loads a descriptor: length in [14:8], upper-valid in [3], access in [1:0]. Kind 2 loads the control/status register. Kind 3 is ignored.
- R10: After reset, every register is zero, so translation is disabled and every descriptor means no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register select {kind, space, page} |
| wr_data | input | 16 | Register write data |
| req_valid | input | 1 | Address request present this cycle |
| req_va | input | 16 | Virtual byte address |
| req_write | input | 1 | Request is a write |
| req_ispace | input | 1 | Request is made through the program counter |
| req_fetch | input | 1 | Request starts an instruction fetch |
| pa | output | 18 | Physical address |
| abort | output | 1 | Request is illegal and must be aborted |
| sr0 | output | 16 | Control/status register: enable, fault page, space, error flags |
| sr2 | output | 16 | Captured fetch address |

## Verification
The hardest case to reach is the frozen fault record. It needs a first fault that is still unacknowledged, followed by a second fault of a different kind, in a different page and in the other address space. Only then does a failure to hold the page and space fields show at the ports. The bench first causes a data-space length fault, then sends an instruction-space request to a page whose descriptor still holds its reset value of no access. It checks that only the flag bits change. It then clears the register and repeats the second fault alone, to show that the same request would otherwise have been recorded. The boundary blocks on either side of the length field are probed for both expansion directions.

// File: rtl/sru_pkg.sv
package sru_pkg;

   // access mode codes held in a descriptor
   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_RO   = 2'b01,
      ACC_RSV  = 2'b10,
      ACC_RW   = 2'b11
   } acc_e;

   // register kinds selected by the top bits of the write address
   typedef enum logic [1:0] {
      KIND_REL  = 2'd0,
      KIND_DESC = 2'd1,
      KIND_CSR  = 2'd2,
      KIND_NONE = 2'd3
   } kind_e;

   // descriptor field positions
   localparam int DESC_LEN_LSB = 8;
   localparam int DESC_UP_BIT  = 3;

   // control/status field positions
   localparam int CSR_EN_BIT   = 0;
   localparam int CSR_PG_LSB   = 1;
   localparam int CSR_ERR_RO   = 13;
   localparam int CSR_ERR_LEN  = 14;
   localparam int CSR_ERR_NACC = 15;

endpackage

// File: rtl/sru_regfile.sv
module sru_regfile
   import sru_pkg::*;
#(
   parameter int NPAGE = 8,
   parameter int REL_W = 12,
   parameter int LEN_W = 7,
   parameter bit SPLIT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_rel,
   input  logic                     wr_desc,
   input  logic                     wr_space,
   input  logic [$clog2(NPAGE)-1:0] wr_page,
   input  logic [REL_W-1:0]         wr_rel_val,
   input  logic [LEN_W-1:0]         wr_len,
   input  logic                     wr_up,
   input  logic [1:0]               wr_acc,
   input  logic                     rd_space,
   input  logic [$clog2(NPAGE)-1:0] rd_page,
   output logic [REL_W-1:0]         rel,
   output logic [LEN_W-1:0]         len,
   output logic                     up,
   output acc_e                     acc
);

   localparam int PG_W = $clog2(NPAGE);
   localparam int NSET = SPLIT ? 2 : 1;

   logic [REL_W-1:0] rel_q [NSET][NPAGE];
   logic [LEN_W-1:0] len_q [NSET][NPAGE];
   logic             up_q  [NSET][NPAGE];
   acc_e             acc_q [NSET][NPAGE];

   for (genvar s = 0; s < NSET; s++) begin : g_set
      for (genvar p = 0; p < NPAGE; p++) begin : g_page
         logic hit;
         if (SPLIT) begin : g_sel
            assign hit = (wr_page == PG_W'(p)) && (wr_space == 1'(s));
         end else begin : g_any
            assign hit = (wr_page == PG_W'(p));
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rel_q[s][p] <= '0;
               len_q[s][p] <= '0;
               up_q[s][p]  <= 1'b0;
               acc_q[s][p] <= ACC_NONE;
            end else begin
               if (wr_rel && hit) begin
                  rel_q[s][p] <= wr_rel_val;
               end
               if (wr_desc && hit) begin
                  len_q[s][p] <= wr_len;
                  up_q[s][p]  <= wr_up;
                  acc_q[s][p] <= acc_e'(wr_acc);
               end
            end
         end
      end
   end

   if (SPLIT) begin : g_rd_split
      assign rel = rel_q[rd_space][rd_page];
      assign len = len_q[rd_space][rd_page];
      assign up  = up_q[rd_space][rd_page];
      assign acc = acc_q[rd_space][rd_page];
   end else begin : g_rd_shared
      logic unused_space;
      assign unused_space = rd_space ^ wr_space;
      assign rel = rel_q[0][rd_page];
      assign len = len_q[0][rd_page];
      assign up  = up_q[0][rd_page];
      assign acc = acc_q[0][rd_page];
   end

endmodule

// File: rtl/sru_xlate.sv
module sru_xlate
   import sru_pkg::*;
#(
   parameter int VA_W   = 16,
   parameter int PA_W   = 18,
   parameter int NPAGE  = 8,
   parameter int BLK_SH = 6
) (
   input  logic                                  en,
   input  logic [VA_W-1:0]                       va,
   input  logic                                  write,
   input  logic [PA_W-BLK_SH-1:0]                rel,
   input  logic [VA_W-$clog2(NPAGE)-BLK_SH-1:0]  len,
   input  logic                                  up,
   input  acc_e                                  acc,
   output logic [$clog2(NPAGE)-1:0]              page,
   output logic [PA_W-1:0]                       pa,
   output logic                                  err_nacc,
   output logic                                  err_len,
   output logic                                  err_ro
);

   localparam int PG_W  = $clog2(NPAGE);
   localparam int OFF_W = VA_W - PG_W;
   localparam int LEN_W = OFF_W - BLK_SH;

   logic [OFF_W-1:0] off;
   logic [LEN_W-1:0] blk;
   logic [PA_W-1:0]  pa_mapped;
   logic [PA_W-1:0]  pa_fixed;
   logic             no_acc;
   logic             outside;

   assign page = va[VA_W-1 -: PG_W];
   assign off  = va[OFF_W-1:0];
   assign blk  = off[OFF_W-1 -: LEN_W];

   // relocated address: base in block units plus in-page offset
   assign pa_mapped = {rel, {BLK_SH{1'b0}}} + PA_W'(off);

   // bypass map: top page lands on the top of physical space
   always_comb begin
      if (&page) begin
         pa_fixed = {{(PA_W-OFF_W){1'b1}}, off};
      end else begin
         pa_fixed = PA_W'(va);
      end
   end

   assign outside = up ? (blk <= len) : (blk > len);
   assign no_acc  = (acc == ACC_NONE) || (acc == ACC_RSV);

   assign pa       = en ? pa_mapped : pa_fixed;
   assign err_nacc = en && no_acc;
   assign err_len  = en && !no_acc && outside;
   assign err_ro   = en && !no_acc && write && (acc == ACC_RO);

endmodule

// File: rtl/sru_status.sv
module sru_status
   import sru_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int VA_W   = 16,
   parameter int PG_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_csr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cap_fetch,
   input  logic [VA_W-1:0]   va,
   input  logic              abort,
   input  logic              err_nacc,
   input  logic              err_len,
   input  logic              err_ro,
   input  logic [PG_W-1:0]   page,
   input  logic              space,
   output logic [DATA_W-1:0] csr,
   output logic [VA_W-1:0]   fetch_va
);

   localparam int SPACE_BIT = CSR_PG_LSB + PG_W;

   logic frozen;
   assign frozen = csr[CSR_ERR_NACC] | csr[CSR_ERR_LEN] | csr[CSR_ERR_RO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csr      <= '0;
         fetch_va <= '0;
      end else begin
         if (cap_fetch) begin
            fetch_va <= va;
         end
         if (wr_csr) begin
            csr <= wr_data;
         end else if (abort) begin
            csr[CSR_ERR_NACC] <= csr[CSR_ERR_NACC] | err_nacc;
            csr[CSR_ERR_LEN]  <= csr[CSR_ERR_LEN]  | err_len;
            csr[CSR_ERR_RO]   <= csr[CSR_ERR_RO]   | err_ro;
            if (!frozen) begin
               csr[CSR_PG_LSB +: PG_W] <= page;
               csr[SPACE_BIT]          <= space;
            end
         end
      end
   end

   // R7: fetch address captured on the next edge
   p_fetch_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fetch |=> fetch_va == $past(va));

   // R8: fault record frozen while flags remain
   p_fault_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !wr_csr) |=> $stable(csr[SPACE_BIT:CSR_PG_LSB]));

   // R3: a length fault always leaves its flag set
   p_len_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && err_len && !wr_csr) |=> csr[CSR_ERR_LEN]);

   // R6: only software changes the enable bit
   p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_csr |=> $stable(csr[CSR_EN_BIT]));

endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
   import sru_pkg::*;
#(
   parameter int VA_W         = 16,
   parameter int PA_W         = 18,
   parameter int NPAGE        = 8,
   parameter int BLK_SH       = 6,
   parameter int DATA_W       = 16,
   parameter bit SPLIT_SPACES = 1'b1,
   localparam int PG_W        = $clog2(NPAGE),
   localparam int WA_W        = PG_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WA_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   input  logic              req_ispace,
   input  logic              req_fetch,
   output logic [PA_W-1:0]   pa,
   output logic              abort,
   output logic [DATA_W-1:0] sr0,
   output logic [VA_W-1:0]   sr2
);

   localparam int OFF_W = VA_W - PG_W;
   localparam int LEN_W = OFF_W - BLK_SH;
   localparam int REL_W = PA_W - BLK_SH;

   // elaboration-time parameter checks
   if (PA_W <= VA_W) begin : g_chk_pa
      $error("physical width must exceed virtual width");
   end
   if ((1 << PG_W) != NPAGE) begin : g_chk_pg
      $error("page count must be a power of two");
   end
   if (LEN_W < 1) begin : g_chk_blk
      $error("block shift leaves no block index");
   end
   if (REL_W > DATA_W) begin : g_chk_rel
      $error("relocation value does not fit the write data");
   end
   if (DESC_LEN_LSB + LEN_W > DATA_W) begin : g_chk_len
      $error("length field does not fit the write data");
   end
   if (CSR_PG_LSB + PG_W >= CSR_ERR_RO) begin : g_chk_csr
      $error("fault page field collides with error flags");
   end
   if (VA_W > DATA_W) begin : g_chk_va
      $error("virtual width exceeds register width");
   end

   kind_e               wr_kind;
   logic                wr_space;
   logic [PG_W-1:0]     wr_page;
   logic [REL_W-1:0]    cur_rel;
   logic [LEN_W-1:0]    cur_len;
   logic                cur_up;
   acc_e                cur_acc;
   logic [PG_W-1:0]     cur_page;
   logic                e_nacc, e_len, e_ro;
   logic                xl_en;

   assign wr_kind  = kind_e'(wr_addr[WA_W-1 -: 2]);
   assign wr_space = wr_addr[PG_W];
   assign wr_page  = wr_addr[PG_W-1:0];
   assign xl_en    = sr0[CSR_EN_BIT];

   sru_regfile #(
      .NPAGE (NPAGE),
      .REL_W (REL_W),
      .LEN_W (LEN_W),
      .SPLIT (SPLIT_SPACES)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_rel     (wr_en && (wr_kind == KIND_REL)),
      .wr_desc    (wr_en && (wr_kind == KIND_DESC)),
      .wr_space   (wr_space),
      .wr_page    (wr_page),
      .wr_rel_val (wr_data[REL_W-1:0]),
      .wr_len     (wr_data[DESC_LEN_LSB +: LEN_W]),
      .wr_up      (wr_data[DESC_UP_BIT]),
      .wr_acc     (wr_data[1:0]),
      .rd_space   (req_ispace),
      .rd_page    (req_va[VA_W-1 -: PG_W]),
      .rel        (cur_rel),
      .len        (cur_len),
      .up         (cur_up),
      .acc        (cur_acc)
   );

   sru_xlate #(
      .VA_W   (VA_W),
      .PA_W   (PA_W),
      .NPAGE  (NPAGE),
      .BLK_SH (BLK_SH)
   ) i_xlate (
      .en       (xl_en),
      .va       (req_va),
      .write    (req_write),
      .rel      (cur_rel),
      .len      (cur_len),
      .up       (cur_up),
      .acc      (cur_acc),
      .page     (cur_page),
      .pa       (pa),
      .err_nacc (e_nacc),
      .err_len  (e_len),
      .err_ro   (e_ro)
   );

   assign abort = req_valid && (e_nacc || e_len || e_ro);

   sru_status #(
      .DATA_W (DATA_W),
      .VA_W   (VA_W),
      .PG_W   (PG_W)
   ) i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_csr    (wr_en && (wr_kind == KIND_CSR)),
      .wr_data   (wr_data),
      .cap_fetch (req_valid && req_fetch),
      .va        (req_va),
      .abort     (abort),
      .err_nacc  (e_nacc),
      .err_len   (e_len),
      .err_ro    (e_ro),
      .page      (cur_page),
      .space     (req_ispace),
      .csr       (sr0),
      .fetch_va  (sr2)
   );

   // R6: bypass map is the identity below the top page
   p_ident_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sr0[CSR_EN_BIT] && !(&req_va[VA_W-1 -: PG_W]))
         |-> (pa == PA_W'(req_va)) && !abort);

endmodule

// File: tb/test_seg_reloc_unit.sv
`timescale 1ns/1ps
module test_seg_reloc_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [5:0]  wr_addr;
   logic [15:0] wr_data;
   logic        req_valid, req_write, req_ispace, req_fetch;
   logic [15:0] req_va;
   logic [17:0] pa;
   logic        abort;
   logic [15:0] sr0, sr2;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   seg_reloc_unit i_seg_reloc_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .req_ispace(req_ispace), .req_fetch(req_fetch),
      .pa(pa), .abort(abort), .sr0(sr0), .sr2(sr2)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [5:0] a_rel(input logic sp, input logic [2:0] pg);
      return {2'd0, sp, pg};
   endfunction
   function automatic logic [5:0] a_desc(input logic sp, input logic [2:0] pg);
      return {2'd1, sp, pg};
   endfunction
   localparam logic [5:0] A_CSR = 6'b100000;
   function automatic logic [15:0] desc(input logic [6:0] ln, input logic u, input logic [1:0] ac);
      return {1'b0, ln, 4'b0000, u, 1'b0, ac};
   endfunction
   function automatic logic [17:0] reloc(input logic [11:0] r, input logic [15:0] va);
      return 18'({r, 6'b0} + {5'b0, va[12:0]});
   endfunction

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // drive one request, sample combinational outputs, then release
   task automatic probe(input logic [15:0] va, input logic w, input logic isp,
                        input logic f, output logic [17:0] p, output logic ab);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = w; req_ispace = isp; req_fetch = f;
      #1;
      p = pa; ab = abort;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0; req_ispace = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      logic [17:0] p; logic ab;
      check("R10 sr0 after reset", 32'(sr0), 32'h0);
      check("R10 sr2 after reset", 32'(sr2), 32'h0);
      probe(16'o160004, 1'b1, 1'b0, 1'b0, p, ab);
      check("R6 top page bypass pa", 32'(p), 32'(18'o760004));
      check("R10 no abort while off", 32'(ab), 32'h0);
      probe(16'h5a5a, 1'b0, 1'b1, 1'b0, p, ab);
      check("R6 identity pa", 32'(p), 32'h05a5a);
   endtask

   task automatic t_map;
      logic [17:0] p; logic ab;
      wr(a_rel(1'b0, 3'd2), 16'o1234);
      wr(a_desc(1'b0, 3'd2), desc(7'd127, 1'b0, 2'b11));
      wr(a_rel(1'b0, 3'd1), 16'h0fff);
      wr(a_desc(1'b0, 3'd1), desc(7'd127, 1'b0, 2'b11));
      wr(A_CSR, 16'h0001);
      probe(16'h4abc, 1'b1, 1'b0, 1'b0, p, ab);
      check("R1 relocated pa", 32'(p), 32'(reloc(12'o1234, 16'h4abc)));
      check("R5 rw write allowed", 32'(ab), 32'h0);
      probe(16'h3fff, 1'b0, 1'b0, 1'b0, p, ab);
      check("R1 wrap modulo 2^18", 32'(p), 32'(reloc(12'hfff, 16'h3fff)));
      wr({2'd3, 1'b0, 3'd2}, 16'hffff);
      check("R9 kind 3 leaves sr0", 32'(sr0), 32'h0001);
      probe(16'h4abc, 1'b0, 1'b0, 1'b0, p, ab);
      check("R9 kind 3 leaves map", 32'(p), 32'(reloc(12'o1234, 16'h4abc)));
   endtask

   task automatic t_space;
      logic [17:0] p; logic ab;
      wr(a_rel(1'b1, 3'd2), 16'o4000);
      wr(a_desc(1'b1, 3'd2), desc(7'd127, 1'b0, 2'b11));
      probe(16'h4abc, 1'b0, 1'b1, 1'b0, p, ab);
      check("R2 instruction set pa", 32'(p), 32'(reloc(12'o4000, 16'h4abc)));
      probe(16'h4abc, 1'b0, 1'b0, 1'b0, p, ab);
      check("R2 data set unchanged", 32'(p), 32'(reloc(12'o1234, 16'h4abc)));
   endtask

   task automatic t_lower;
      logic [17:0] p; logic ab;
      wr(a_rel(1'b0, 3'd3), 16'h0000);
      wr(a_desc(1'b0, 3'd3), desc(7'd9, 1'b0, 2'b11));
      probe(16'h6240, 1'b0, 1'b0, 1'b0, p, ab);
      check("R3 last valid block", 32'(ab), 32'h0);
      check("R3 no flag", 32'(sr0), 32'h0001);
      probe(16'h6280, 1'b0, 1'b0, 1'b0, p, ab);
      check("R3 block past length aborts", 32'(ab), 32'h1);
      check("R8 R3 fault record", 32'(sr0), 32'h4007);
      wr(A_CSR, 16'h0001);
      check("R8 software clear", 32'(sr0), 32'h0001);
   endtask

   task automatic t_upper;
      logic [17:0] p; logic ab;
      wr(a_desc(1'b0, 3'd4), desc(7'd9, 1'b1, 2'b11));
      probe(16'h8280, 1'b0, 1'b0, 1'b0, p, ab);
      check("R4 first upper block ok", 32'(ab), 32'h0);
      probe(16'h8240, 1'b0, 1'b0, 1'b0, p, ab);
      check("R4 block at length aborts", 32'(ab), 32'h1);
      check("R4 fault record", 32'(sr0), 32'h4009);
      wr(A_CSR, 16'h0001);
   endtask

   task automatic t_mode;
      logic [17:0] p; logic ab;
      wr(a_desc(1'b0, 3'd5), desc(7'd127, 1'b0, 2'b01));
      probe(16'ha010, 1'b0, 1'b0, 1'b0, p, ab);
      check("R5 read-only read ok", 32'(ab), 32'h0);
      probe(16'ha010, 1'b1, 1'b0, 1'b0, p, ab);
      check("R5 read-only write aborts", 32'(ab), 32'h1);
      check("R5 read-only flag", 32'(sr0), 32'h200b);
      wr(A_CSR, 16'h0001);
      wr(a_desc(1'b0, 3'd6), desc(7'd127, 1'b0, 2'b00));
      probe(16'hc000, 1'b0, 1'b0, 1'b0, p, ab);
      check("R5 no-access aborts", 32'(ab), 32'h1);
      check("R5 no-access flag", 32'(sr0), 32'h800d);
      wr(A_CSR, 16'h0001);
      wr(a_desc(1'b0, 3'd6), desc(7'd127, 1'b0, 2'b10));
      probe(16'hc000, 1'b0, 1'b0, 1'b0, p, ab);
      check("R5 code 10 aborts", 32'(ab), 32'h1);
      check("R5 code 10 flag", 32'(sr0), 32'h800d);
      wr(A_CSR, 16'h0001);
   endtask

   task automatic t_freeze;
      logic [17:0] p; logic ab;
      probe(16'h6280, 1'b0, 1'b0, 1'b0, p, ab);
      check("R8 first fault", 32'(sr0), 32'h4007);
      probe(16'ha000, 1'b0, 1'b1, 1'b0, p, ab);
      check("R8 second fault aborts", 32'(ab), 32'h1);
      check("R8 record frozen, flags add", 32'(sr0), 32'hc007);
      wr(A_CSR, 16'h0001);
      probe(16'ha000, 1'b0, 1'b1, 1'b0, p, ab);
      check("R8 instruction space record", 32'(sr0), 32'h801b);
      wr(A_CSR, 16'h0001);
   endtask

   task automatic t_fetch;
      logic [17:0] p; logic ab;
      probe(16'h4abc, 1'b0, 1'b1, 1'b1, p, ab);
      check("R7 fetch captured", 32'(sr2), 32'h4abc);
      probe(16'h1234, 1'b0, 1'b0, 1'b0, p, ab);
      check("R7 non-fetch ignored", 32'(sr2), 32'h4abc);
      probe(16'ha000, 1'b0, 1'b1, 1'b1, p, ab);
      check("R7 aborted fetch captured", 32'(sr2), 32'ha000);
      wr(A_CSR, 16'h0001);
   endtask

   task automatic t_disabled;
      logic [17:0] p; logic ab;
      wr(A_CSR, 16'h0000);
      probe(16'h6280, 1'b1, 1'b0, 1'b0, p, ab);
      check("R6 off: no length abort", 32'(ab), 32'h0);
      check("R6 off: identity", 32'(p), 32'h06280);
      probe(16'hffff, 1'b0, 1'b1, 1'b0, p, ab);
      check("R6 off: top of page 7", 32'(p), 32'h3ffff);
      check("R6 off: no flags", 32'(sr0), 32'h0000);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      req_valid = 1'b0; req_va = '0; req_write = 1'b0;
      req_ispace = 1'b0; req_fetch = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_map();
      t_space();
      t_lower();
      t_upper();
      t_mode();
      t_freeze();
      t_fetch();
      t_disabled();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule